// File: doc/BRIEF.md
# Burst-Correcting Pager Codeword Decoder

This block receives one 32-bit pager codeword serially, one bit per bit tick, first-transmitted bit first. While the bits arrive it divides the first 31 of them by the code's generator polynomial with a serial shift register, and it accumulates a parity bit over all 32. Once the last bit is in, the remainder (syndrome) is matched against every syndrome that a single flipped bit or a pair of flipped neighbouring bits would leave. A match names the bits to invert. Any other non-zero syndrome is reported as uncorrectable, and the word is then left as received.

The first bit of the corrected word tells the two word types apart. A 1 marks a message word. The block then sends a 23-bit result on a serial data line with a matching strobe, made of three parts in this order:
- the 20 corrected information bits, first-received first;
- a two-bit error class;
- a parity flag.

A 0 marks an address or idle word. The block then pulses a stop line once and sends nothing. Word alignment comes from reset: the first bit tick after reset starts a codeword, and every 32 ticks after that start the next one.

Top module: `bch_burst_decoder`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, `out_strobe` and `word_stop` are 0. `out_data` is 0 during reset.
- R2: A message word received with no error emits exactly 23 strobed bits in this order: received bits 2 to 21 (bit 2 first), then error class bits E0 and E1, then the parity flag. For an error-free word the class is E0=0, E1=0 and the parity flag is 0.
- R3: A single inverted bit anywhere in bits 1 to 31 is corrected before output, and the class is E0=1, E1=0.
- R4: Two inverted neighbouring bits anywhere in bits 1 to 31 are corrected before output, and the class is E0=0, E1=1.
- R5: Two inverted bits in bits 1 to 31 that are not neighbours are not corrected. The class is E0=1, E1=1, and the emitted data bits are the received ones.
- R6: The parity flag is 1 exactly when the 32 received bits, taken before correction, contain an odd number of ones. An inverted bit 32 on its own gives correct data, class 00 and flag 1.
- R7: When bit 1 after correction is 0, `word_stop` pulses for one cycle and no strobe is produced for that word. When bit 1 after correction is 1, no stop pulse is produced.
- R8: Each strobe lasts one clock. `out_data` holds its value for at least one clock before and one clock after every strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; also realigns the codeword boundary |
| in_valid | input | 1 | Bit tick: one received bit is taken on each clock where this is 1 |
| in_bit | input | 1 | Received bit, qualified by `in_valid` |
| out_data | output | 1 | Serial result data line |
| out_strobe | output | 1 | One-clock pulse per emitted result bit |
| word_stop | output | 1 | One-clock pulse when the corrected word is an address or idle word |

## Verification
A wrong syndrome or a mis-built flip mask shows up in the next result. The bench sees it as a wrong E0/E1 pair or as wrong data bits, about a hundred clocks after the word's last bit tick. A bit counter that has slipped misaligns every later word. Each of those words then looks uncorrectable, or it turns a message into a stop pulse, so one bad word exposes it. A parity accumulator that is not cleared between words gives a wrong final flag on every second word or so. Timing faults in the output pacer break the one-clock window on each side of the strobe and are caught at the first bit emitted.

// File: rtl/bch_dec_pkg.sv
// Package: code geometry, the error class encoding and the polynomial
// helpers that the decoder sub-blocks share.
// Assumes the (31,21) cyclic code with generator
// x^10+x^9+x^8+x^6+x^5+x^3+1, plus one overall parity bit.
package bch_dec_pkg;

    localparam int CW_BITS     = 32;
    localparam int CODE_BITS   = CW_BITS - 1;
    localparam int CHECK_BITS  = 10;
    localparam int DATA_BITS   = 20;
    localparam int RESULT_BITS = DATA_BITS + 3;
    localparam int CNT_W       = $clog2(CW_BITS);
    localparam int PAIR_COUNT  = CODE_BITS - 1;

    // Generator polynomial without its x^10 term.
    localparam logic [CHECK_BITS-1:0] GEN_LOW = 10'b11_0110_1001;

    // Bit 1 of the code is E0 and goes out first; bit 0 is E1.
    typedef enum logic [1:0] {
        ERR_NONE   = 2'b00,
        ERR_SINGLE = 2'b10,
        ERR_PAIR   = 2'b01,
        ERR_UNCORR = 2'b11
    } err_class_t;

    // One division step: remainder times x plus the new bit, reduced.
    function automatic logic [CHECK_BITS-1:0] rem_step(
        input logic [CHECK_BITS-1:0] rem,
        input logic                  din
    );
        return {rem[CHECK_BITS-2:0], din} ^ (rem[CHECK_BITS-1] ? GEN_LOW : '0);
    endfunction

    // x^deg reduced by the generator: syndrome of one error at degree deg.
    function automatic logic [CHECK_BITS-1:0] pow_syn(input int deg);
        logic [CHECK_BITS-1:0] r;
        r = {{(CHECK_BITS-1){1'b0}}, 1'b1};
        for (int i = 0; i < deg; i++) begin
            r = rem_step(r, 1'b0);
        end
        return r;
    endfunction

endpackage

// File: rtl/bch_syn_accum.sv
// Serial front end: counts bit ticks, assembles the 32-bit word, divides
// the first 31 bits by the generator and accumulates parity over all 32.
// Assumes the first tick after reset starts a codeword. word_done pulses
// the cycle after the 32nd tick; the outputs then stay valid until the
// next tick arrives.
module bch_syn_accum
    import bch_dec_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_bit,
    output logic [CW_BITS-1:0]    word,
    output logic [CHECK_BITS-1:0] syndrome,
    output logic                  par_odd,
    output logic                  word_done
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CW_BITS - 1);
    localparam logic [CNT_W-1:0] CODE_END = CNT_W'(CODE_BITS - 1);

    logic [CNT_W-1:0] bit_cnt;
    logic             first_bit;
    logic             in_code;

    assign first_bit = (bit_cnt == '0);
    assign in_code   = (bit_cnt <= CODE_END);

    // Shift in each bit and update the count, remainder and parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            word      <= '0;
            syndrome  <= '0;
            par_odd   <= 1'b0;
            word_done <= 1'b0;
        end else begin
            word_done <= in_valid && (bit_cnt == LAST_IDX);
            if (in_valid) begin
                word    <= {word[CW_BITS-2:0], in_bit};
                par_odd <= (first_bit ? 1'b0 : par_odd) ^ in_bit;
                if (in_code) begin
                    syndrome <= rem_step(first_bit ? '0 : syndrome, in_bit);
                end
                bit_cnt <= (bit_cnt == LAST_IDX) ? '0 : bit_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bch_err_locator.sv
// Error locator: compares the syndrome with the constant syndromes of all
// single errors and all neighbouring-pair errors over the 31 code bits,
// and produces the mask of word bits to invert plus the error class.
// The word bit holding the error of degree d is index d+1; index 0 is the
// overall parity bit, which the code does not cover.
module bch_err_locator
    import bch_dec_pkg::*;
(
    input  logic [CHECK_BITS-1:0] syndrome,
    output logic [CW_BITS-1:0]    flip_mask,
    output err_class_t            err_class
);

    logic [CODE_BITS-1:0]  single_hit;
    logic [PAIR_COUNT-1:0] pair_hit;

    // One comparator per single-bit error position.
    for (genvar d = 0; d < CODE_BITS; d++) begin : g_single
        localparam logic [CHECK_BITS-1:0] SYN_ONE = pow_syn(d);
        assign single_hit[d] = (syndrome == SYN_ONE);
    end

    // One comparator per neighbouring pair (degrees d and d+1).
    for (genvar d = 0; d < PAIR_COUNT; d++) begin : g_pair
        localparam logic [CHECK_BITS-1:0] SYN_TWO = pow_syn(d) ^ pow_syn(d + 1);
        assign pair_hit[d] = (syndrome == SYN_TWO);
    end

    // Turn the comparator hits into a mask over the word's bit positions.
    always_comb begin
        flip_mask = '0;
        for (int d = 0; d < CODE_BITS; d++) begin
            flip_mask[d+1] = flip_mask[d+1] | single_hit[d];
        end
        for (int d = 0; d < PAIR_COUNT; d++) begin
            flip_mask[d+1] = flip_mask[d+1] | pair_hit[d];
            flip_mask[d+2] = flip_mask[d+2] | pair_hit[d];
        end
    end

    // Classify: zero syndrome, single hit, pair hit or no match.
    always_comb begin
        if (syndrome == '0)   err_class = ERR_NONE;
        else if (|single_hit) err_class = ERR_SINGLE;
        else if (|pair_hit)   err_class = ERR_PAIR;
        else                  err_class = ERR_UNCORR;
    end

endmodule

// File: rtl/bch_result_serializer.sv
// Result stage: on word_done it applies the flip mask and checks the
// corrected first bit. For a message it sends a 23-bit result, one bit
// every PHASES clocks: the data changes in phase 0, the strobe is high in
// phase 1, and the data holds until the end of the period. For any other
// word it pulses word_stop.
// Assumes PHASES >= 3 and bit ticks at least PHASES clocks apart, so a
// result is finished before the next word completes.
module bch_result_serializer
    import bch_dec_pkg::*;
#(
    parameter int PHASES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               word_done,
    input  logic [CW_BITS-1:0] word,
    input  logic [CW_BITS-1:0] flip_mask,
    input  err_class_t         err_class,
    input  logic               par_odd,
    output logic               out_data,
    output logic               out_strobe,
    output logic               word_stop
);

    localparam int PH_W   = $clog2(PHASES);
    localparam int BCNT_W = $clog2(RESULT_BITS);
    localparam logic [PH_W-1:0]   PH_LAST  = PH_W'(PHASES - 1);
    localparam logic [BCNT_W-1:0] BIT_LAST = BCNT_W'(RESULT_BITS - 1);
    localparam int DATA_TOP = CW_BITS - 2;
    localparam int DATA_BOT = CW_BITS - 1 - DATA_BITS;

    logic [CW_BITS-1:0]     corrected;
    logic [RESULT_BITS-1:0] load_word;
    logic [RESULT_BITS-1:0] shifter;
    logic [PH_W-1:0]        phase;
    logic [BCNT_W-1:0]      bit_idx;
    logic                   busy;

    assign corrected = word ^ flip_mask;
    assign load_word = {corrected[DATA_TOP:DATA_BOT], err_class, par_odd};
    assign out_data  = shifter[RESULT_BITS-1];

    // Load a message result or flag a stop; then pace the bits out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shifter    <= '0;
            phase      <= '0;
            bit_idx    <= '0;
            busy       <= 1'b0;
            out_strobe <= 1'b0;
            word_stop  <= 1'b0;
        end else begin
            word_stop  <= 1'b0;
            out_strobe <= busy && (phase == '0);
            if (word_done) begin
                if (corrected[CW_BITS-1]) begin
                    shifter <= load_word;
                    busy    <= 1'b1;
                    phase   <= '0;
                    bit_idx <= '0;
                end else begin
                    word_stop <= 1'b1;
                end
            end else if (busy) begin
                if (phase == PH_LAST) begin
                    phase   <= '0;
                    shifter <= {shifter[RESULT_BITS-2:0], 1'b0};
                    if (bit_idx == BIT_LAST) begin
                        busy <= 1'b0;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                    end
                end else begin
                    phase <= phase + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bch_burst_decoder.sv
// Top level: serial syndrome front end, combinational error locator and
// paced result serializer, wired in that order.
// Assumes the first bit tick after reset starts a codeword.
module bch_burst_decoder
    import bch_dec_pkg::*;
#(
    parameter int PHASES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_bit,
    output logic out_data,
    output logic out_strobe,
    output logic word_stop
);

    logic [CW_BITS-1:0]    word;
    logic [CHECK_BITS-1:0] syndrome;
    logic                  par_odd;
    logic                  word_done;
    logic [CW_BITS-1:0]    flip_mask;
    err_class_t            err_class;

    bch_syn_accum u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .word      (word),
        .syndrome  (syndrome),
        .par_odd   (par_odd),
        .word_done (word_done)
    );

    bch_err_locator u_locate (
        .syndrome  (syndrome),
        .flip_mask (flip_mask),
        .err_class (err_class)
    );

    bch_result_serializer #(.PHASES(PHASES)) u_serial (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_done  (word_done),
        .word       (word),
        .flip_mask  (flip_mask),
        .err_class  (err_class),
        .par_odd    (par_odd),
        .out_data   (out_data),
        .out_strobe (out_strobe),
        .word_stop  (word_stop)
    );

endmodule

// File: rtl/bch_decoder_chk.sv
// Checker bound to the decoder top: output pacing, the stop indication,
// and consistency between the error class and the flip mask.
module bch_decoder_chk
    import bch_dec_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               out_data,
    input logic               out_strobe,
    input logic               word_stop,
    input logic               word_done,
    input logic [CW_BITS-1:0] flip_mask,
    input err_class_t         err_class
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!out_strobe && !word_stop));

    // R8
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_strobe |=> !out_strobe);

    // R8
    data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_strobe |-> $stable(out_data));

    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_strobe |=> $stable(out_data));

    // R7
    stop_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_stop |-> $past(word_done));

    // R7
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_stop |-> !out_strobe);

    // R3
    single_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_class == ERR_SINGLE) |-> ($countones(flip_mask) == 1));

    // R4
    pair_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_class == ERR_PAIR) |-> ($countones(flip_mask) == 2));

    // R5
    no_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_class == ERR_UNCORR || err_class == ERR_NONE) |-> (flip_mask == '0));

endmodule

bind bch_burst_decoder bch_decoder_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_data   (out_data),
    .out_strobe (out_strobe),
    .word_stop  (word_stop),
    .word_done  (word_done),
    .flip_mask  (flip_mask),
    .err_class  (err_class)
);

// File: tb/bch_burst_decoder_tb_top.sv
module bch_burst_decoder_tb_top;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid;
    logic in_bit;
    logic out_data;
    logic out_strobe;
    logic word_stop;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // Monitor state (written only by the monitor process).
    int          rx_total   = 0;
    int          stop_total = 0;
    int          viol_total = 0;
    logic [31:0] rx_shift   = '0;
    logic        prev_data  = 1'b0;
    logic        prev_strobe = 1'b0;

    always #5 clk = ~clk;

    bch_burst_decoder #(.PHASES(4)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_bit     (in_bit),
        .out_data   (out_data),
        .out_strobe (out_strobe),
        .word_stop  (word_stop)
    );

    // Sample outputs at the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (out_strobe) begin
                rx_shift <= {rx_shift[30:0], out_data};
                rx_total <= rx_total + 1;
                if (out_data !== prev_data) viol_total <= viol_total + 1;
            end
            if (prev_strobe && (out_data !== prev_data)) viol_total <= viol_total + 1;
            if (prev_strobe && out_strobe) viol_total <= viol_total + 1;
            if (word_stop) stop_total <= stop_total + 1;
        end
        prev_data   <= out_data;
        prev_strobe <= out_strobe;
    end

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Systematic encoder built from the requirements: 21 info bits, then
    // 10 check bits, then even parity over the 31.
    function automatic logic [31:0] encode(input logic [20:0] info);
        logic [9:0] r;
        logic       fb;
        logic [30:0] c;
        r = '0;
        for (int i = 20; i >= 0; i--) begin
            fb = info[i] ^ r[9];
            r  = {r[8:0], 1'b0};
            if (fb) r = r ^ 10'b11_0110_1001;
        end
        c = {info, r};
        return {c, ^c};
    endfunction

    task automatic send_word(input logic [31:0] w);
        for (int k = 31; k >= 0; k--) begin
            @(posedge clk); #1;
            in_valid = 1'b1;
            in_bit   = w[k];
            @(posedge clk); #1;
            in_valid = 1'b0;
            repeat (2) @(posedge clk);
        end
    endtask

    // kind: 0 clean, 1 single, 2 pair, 3 non-neighbour double, 4 parity bit
    task automatic run_word(input logic [31:0] clean, input logic [31:0] err,
                            input int kind);
        int r0, s0, v0;
        logic [31:0] rx, corr;
        logic [1:0]  cls;
        logic [22:0] exp_res;
        string tag;
        r0 = rx_total; s0 = stop_total; v0 = viol_total;
        rx = clean ^ err;
        send_word(rx);
        repeat (130) @(posedge clk);
        #1;
        case (kind)
            1: begin cls = 2'b10; corr = clean; tag = "R3"; end
            2: begin cls = 2'b01; corr = clean; tag = "R4"; end
            3: begin cls = 2'b11; corr = rx;    tag = "R5"; end
            4: begin cls = 2'b00; corr = clean; tag = "R6"; end
            default: begin cls = 2'b00; corr = clean; tag = "R2"; end
        endcase
        exp_res = {corr[30:11], cls, ^rx};
        if (corr[31]) begin
            check(rx_total - r0 == 23, "R2 strobe count", 32'(rx_total - r0), 32'd23);
            check(rx_shift[22:0] == exp_res, tag, {9'd0, rx_shift[22:0]}, {9'd0, exp_res});
            check(stop_total == s0, "R7 no stop on message", 32'(stop_total - s0), 32'd0);
        end else begin
            check(rx_total == r0, "R7 no strobes on stop", 32'(rx_total - r0), 32'd0);
            check(stop_total - s0 == 1, "R7 stop pulse", 32'(stop_total - s0), 32'd1);
        end
        check(viol_total == v0, "R8 strobe timing", 32'(viol_total - v0), 32'd0);
    endtask

    function automatic logic [31:0] bitmask(input int idx);
        return 32'd1 << idx;
    endfunction

    initial begin
        logic [20:0] info;
        int p, q, kind;
        logic [31:0] err;
        void'($urandom(32'd4711));
        rst_n = 1'b0; in_valid = 1'b0; in_bit = 1'b0;
        repeat (5) @(posedge clk);
        #1;
        check(!out_strobe && !word_stop && !out_data, "R1 reset outputs",
              {29'd0, out_strobe, word_stop, out_data}, 32'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(!out_strobe && !word_stop, "R1 after release",
              {30'd0, out_strobe, word_stop}, 32'd0);
        repeat (3) @(posedge clk);

        // Directed corner cases.
        run_word(encode(21'h1A5C3F), 32'd0, 0);                  // clean message
        run_word(encode(21'h0ABCDE), 32'd0, 0);                  // clean address -> R7
        run_word(encode(21'h155555), bitmask(31), 1);            // bit 1 hit, message
        run_word(encode(21'h055555), bitmask(31), 1);            // bit 1 hit, address
        run_word(encode(21'h1FFFFF), bitmask(1), 1);             // bit 31
        run_word(encode(21'h13579B), bitmask(31) | bitmask(30), 2); // bits 1,2
        run_word(encode(21'h10F0F0), bitmask(1) | bitmask(2), 2);   // bits 30,31
        run_word(encode(21'h1C0FFE), bitmask(11) | bitmask(10), 2); // across 21/22
        run_word(encode(21'h1BEEF1), bitmask(0), 4);             // parity bit only
        run_word(encode(21'h1DEAD5), bitmask(5) | bitmask(20), 3);  // non-neighbours
        run_word(encode(21'h100000), bitmask(12) | bitmask(14), 3);

        // Constrained random words.
        for (int n = 0; n < 40; n++) begin
            info = 21'($urandom);
            kind = int'($urandom % 5);
            err  = '0;
            case (kind)
                1: err = bitmask(1 + int'($urandom % 31));
                2: begin p = 1 + int'($urandom % 30); err = bitmask(p) | bitmask(p + 1); end
                3: begin
                    p = 1 + int'($urandom % 31);
                    q = p;
                    while ((q - p) < 2 && (p - q) < 2) q = 1 + int'($urandom % 31);
                    err = bitmask(p) | bitmask(q);
                end
                4: err = bitmask(0);
                default: err = '0;
            endcase
            run_word(encode(info), err, kind);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1_900_000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule